// File: doc/BRIEF.md
# Dual Interval Timer

This block holds one or two independent interval timers behind a small word-addressed register port. Each timer has a control word, a reload word and a live counter. Software writes a reload value and then writes the control word with the run bit set. The counter starts from the reload value and counts either up or down by one on every clock. When it reaches its terminal value, the timer latches an expiry flag. It then either restarts from the reload value or stops, depending on its auto-restart bit.

The timers share one interrupt output. The output is high while any timer has both its expiry flag and its interrupt-enable bit set. Any write to a timer's control word clears that timer's flag. A read is answered one clock after it is accepted. Only full-word accesses, with all byte enables set, are honoured.

Top module: `dual_itimer`

## Requirements
- R1: After reset, every control, reload and counter word reads as zero, and `irq` is low.
- R2: A control write stores bits [10:0] of the write data and always stores bit 8 (the expiry flag) as 0. Bits [31:11] read back as zero.
- R3: A control write with bit 7 set copies the reload word into the counter and starts counting. A control write with bit 7 clear stops the timer, and a stopped counter holds its value.
- R4: With control bit 1 set, a running counter decreases by one per clock. On the clock after it has reached zero, the timer sets flag bit 8.
- R5: With control bit 1 clear, a running counter increases by one per clock. On the clock after it has reached 32'hFFFFFFFF, the timer sets flag bit 8.
- R6: On expiry with control bit 4 set, the counter is reloaded from the reload word and keeps running. With bit 4 clear, the timer stops and the counter holds its terminal value.
- R7: A write to the reload word does not change a running count. The new value takes effect only at the next start or auto-restart.
- R8: `irq` is high exactly when some present timer has both control bit 8 and control bit 6 set.
- R9: Word address bits [1:0] select the register: 0 is control, 1 is reload, 2 is the counter. The higher address bits select the timer. A counter read returns the live count.
- R10: The following accesses are ignored, and reads of them return zero: word 3, a timer index at or above NUM_TMR, and any access whose byte enables are not all set. The counter word is read-only.
- R11: Every accepted read raises `rsp_valid` for exactly one clock, on the following cycle. `rsp_data` is zero whenever `rsp_valid` is low.
- R12: When a control write and an expiry happen in the same clock, the write wins. The flag stays clear and the run state follows bit 7 of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | DW/8 | Byte enables; all must be set |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read response data |
| irq | output | 1 | Shared interrupt |

## Verification
The bench builds the block with two timers and a 4-bit word address. With these values the timer index can reach 2 and 3, which are absent timers, as well as the unused fourth word of each present timer. This makes the ignore-and-read-zero paths reachable. The up-counting case starts close to all-ones, so it wraps within a few dozen clocks. A control write is timed to land on the exact clock of a down-count expiry, to exercise the write-wins rule.

// File: rtl/dual_itimer.sv
module dual_itimer #(
  parameter int NUM_TMR = 2,
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int CW      = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW/8-1:0] req_be,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            irq
);
  localparam int SW   = AW - 2;
  localparam int DWN  = 1;
  localparam int ARL  = 4;
  localparam int IEN  = 6;
  localparam int ENA  = 7;
  localparam int FLAG = 8;

  logic [NUM_TMR-1:0][CW-1:0] ctl_v;
  logic [NUM_TMR-1:0][DW-1:0] ld_v;
  logic [NUM_TMR-1:0][DW-1:0] cnt_v;
  logic [NUM_TMR-1:0]         run_v;
  logic [NUM_TMR-1:0]         irq_v;
  logic [DW-1:0]              rd_val;

  wire [SW-1:0] sel  = req_addr[AW-1:2];
  wire [1:0]    word = req_addr[1:0];
  wire acc_ok = req_valid & (&req_be) & (int'(sel) < NUM_TMR) & (word != 2'd3);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic [CW-1:0] ctl_r;
    logic [DW-1:0] ld_r, cnt_r;
    logic          run_r;
    wire wr_me  = acc_ok & req_write & (sel == SW'(t));
    wire term   = ctl_r[DWN] ? (cnt_r == '0) : (&cnt_r);
    wire expire = run_r & term;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_r <= '0;
        ld_r  <= '0;
        cnt_r <= '0;
        run_r <= 1'b0;
      end else if (wr_me && word == 2'd0) begin
        ctl_r <= req_wdata[CW-1:0] & ~(CW'(1) << FLAG);
        run_r <= req_wdata[ENA];
        if (req_wdata[ENA]) cnt_r <= ld_r;
      end else begin
        if (wr_me && word == 2'd1) ld_r <= req_wdata;
        if (expire) begin
          ctl_r[FLAG] <= 1'b1;
          if (ctl_r[ARL]) cnt_r <= ld_r;
          else            run_r <= 1'b0;
        end else if (run_r) begin
          cnt_r <= ctl_r[DWN] ? cnt_r - DW'(1) : cnt_r + DW'(1);
        end
      end
    end

    assign ctl_v[t] = ctl_r;
    assign ld_v[t]  = ld_r;
    assign cnt_v[t] = cnt_r;
    assign run_v[t] = run_r;
    assign irq_v[t] = ctl_r[FLAG] & ctl_r[IEN];
  end

  assign irq = |irq_v;

  always_comb begin
    rd_val = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (acc_ok && sel == SW'(t)) begin
        case (word)
          2'd0:    rd_val = DW'(ctl_v[t]);
          2'd1:    rd_val = ld_v[t];
          2'd2:    rd_val = cnt_v[t];
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_data  <= (req_valid & ~req_write) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk #(
  parameter int NUM_TMR = 2,
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int CW      = 11
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [AW-1:0]              req_addr,
  input logic [DW/8-1:0]            req_be,
  input logic                       rsp_valid,
  input logic [DW-1:0]              rsp_data,
  input logic [NUM_TMR-1:0][CW-1:0] ctl_v,
  input logic [NUM_TMR-1:0][DW-1:0] cnt_v,
  input logic [NUM_TMR-1:0]         run_v
);
  // R11
  rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && rsp_data == '0));

  // R10
  partial_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !(&req_be)) |=> rsp_data == '0);

  // R2
  ctl_wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (&req_be) && req_addr == '0) |=> !ctl_v[0][8]);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_v[0] && ctl_v[0][1] && cnt_v[0] != '0 && !req_valid)
      |=> cnt_v[0] == $past(cnt_v[0]) - DW'(1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_v[0] && !req_valid) |=> $stable(cnt_v[0]));
endmodule

bind dual_itimer itimer_chk #(.NUM_TMR(NUM_TMR), .DW(DW), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .ctl_v(ctl_v), .cnt_v(cnt_v), .run_v(run_v)
);

// File: tb/dual_itimer_tb_top.sv
module dual_itimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, irq;
  logic [31:0] rsp_data;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  dual_itimer #(.NUM_TMR(2), .DW(32), .AW(4), .CW(11)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq));

  logic [31:0] m_ctl [2], m_ld [2], m_cnt [2];
  bit          m_run [2];
  bit          m_rv;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    int idx, w;
    bit ok, wr_t, term;
    logic [31:0] old_ld;
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_ctl[t] = 0; m_ld[t] = 0; m_cnt[t] = 0; m_run[t] = 0;
      end
      m_rv = 0; m_rd = 0;
    end else begin
      idx = int'(req_addr) / 4;
      w   = int'(req_addr) % 4;
      ok  = req_valid && req_be == 4'hF && idx < 2 && w != 3;
      m_rv = req_valid && !req_write;
      m_rd = 0;
      if (m_rv && ok)
        m_rd = (w == 0) ? m_ctl[idx] : (w == 1) ? m_ld[idx] : m_cnt[idx];
      for (int t = 0; t < 2; t++) begin
        wr_t = ok && req_write && idx == t;
        term = m_ctl[t][1] ? (m_cnt[t] == 0) : (m_cnt[t] == 32'hFFFF_FFFF);
        old_ld = m_ld[t];
        if (wr_t && w == 0) begin
          m_ctl[t] = req_wdata & 32'h0000_06FF;
          m_run[t] = req_wdata[7];
          if (req_wdata[7]) m_cnt[t] = old_ld;
        end else begin
          if (wr_t && w == 1) m_ld[t] = req_wdata;
          if (m_run[t] && term) begin
            m_ctl[t][8] = 1'b1;
            if (m_ctl[t][4]) m_cnt[t] = old_ld;
            else             m_run[t] = 0;
          end else if (m_run[t]) begin
            m_cnt[t] = m_ctl[t][1] ? m_cnt[t] - 1 : m_cnt[t] + 1;
          end
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_irq;
    if (!done) begin
      e_irq = (m_ctl[0][8] & m_ctl[0][6]) | (m_ctl[1][8] & m_ctl[1][6]);
      if (!rst_n) begin
        check("R1 reset outputs", {30'b0, rsp_valid, irq}, 32'h0);
      end else begin
        check("R8 irq", {31'b0, irq}, {31'b0, e_irq});
        if (m_rv || rsp_valid) begin
          check("R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
          check(cur_tag, rsp_data, m_rd);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [3:0] be = 4'hF);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0; req_be = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd("R1 reset readback", 4'(a));

    // R2: mask and flag clearing; R9 address map
    wr(4'd0, 32'hFFFF_FF7F);
    rd("R2 ctl readback", 4'd0);
    wr(4'd5, 32'hDEAD_BEEF);
    rd("R9 timer1 reload", 4'd5);
    rd("R9 timer0 reload untouched", 4'd1);

    // R4 down count, R6 stop without auto-restart
    wr(4'd1, 32'd5);
    wr(4'd0, 32'h0000_0082);
    rd("R9 live count", 4'd2);
    idle(8);
    rd("R4 flag after zero", 4'd0);
    rd("R6 held terminal", 4'd2);
    idle(3);
    rd("R6 still held", 4'd2);

    // R8 interrupt from timer1
    wr(4'd5, 32'd3);
    wr(4'd4, 32'h0000_00C2);
    idle(8);
    rd("R8 flag with ie", 4'd4);
    wr(4'd4, 32'h0000_0040);
    rd("R8 cleared", 4'd4);

    // R5 up count with R6 auto-restart
    wr(4'd5, 32'hFFFF_FFF8);
    wr(4'd4, 32'h0000_0090);
    rd("R5 up count", 4'd6);
    idle(10);
    rd("R5 flag after wrap", 4'd4);
    rd("R6 restarted count", 4'd6);
    // R7 reload write while running
    wr(4'd5, 32'hFFFF_FF00);
    rd("R7 count unaffected", 4'd6);
    idle(12);
    rd("R7 new reload used", 4'd6);
    wr(4'd4, 32'h0);

    // R10 ignored accesses
    wr(4'd8, 32'h1234_5678);
    wr(4'd3, 32'h1234_5678);
    wr(4'd1, 32'hAAAA_AAAA, 4'h3);
    wr(4'd2, 32'h5555_5555);
    rd("R10 absent timer", 4'd8);
    rd("R10 unused word", 4'd3);
    rd("R10 partial write ignored", 4'd1);
    rd("R10 partial read zero", 4'd1, 4'h7);
    rd("R10 counter read-only", 4'd2);

    // R12 control write on the expiry clock; R3 stop holds count
    wr(4'd1, 32'd4);
    wr(4'd0, 32'h0000_00D2);
    idle(3);
    wr(4'd0, 32'h0000_0052);
    rd("R12 flag stays clear", 4'd0);
    rd("R3 stopped count", 4'd2);
    idle(4);
    rd("R3 count held", 4'd2);
    wr(4'd0, 32'h0000_0082);
    rd("R3 restart from reload", 4'd2);
    idle(10);

    finish_run();
  end
endmodule